// File: doc/BRIEF.md
# Byte-Wide Window onto Word Receive and Transmit Queues

This block lets a host with an 8-bit data bus move 16-bit words to and from one serial channel. It holds two small word queues. The receive queue is filled by the serial engine and drained by the host. The transmit queue is filled by the host and drained by the serial engine. The host sees the two queues through a window of two byte offsets. Offset 0 carries the upper half of a word and offset 1 carries the lower half.

Only an access to the lower half moves a queue. A lower-half read takes the oldest receive word off its queue. A lower-half write commits a word to the transmit queue. That word joins the upper byte, written earlier into a holding register, with the byte now on the bus. So a correct 16-bit transfer accesses offset 0 first and offset 1 second.

Two status flags report the queue levels. Two sticky bits record traffic that was lost. The serial side gets a plain push port and a plain pop port.

Top module: `byte_fifo_port`

## Requirements
- R1: Each queue holds up to 4 words of 16 bits. `rx_not_empty` is 1 exactly when the receive queue holds at least one word. `tx_not_full` is 1 exactly when the transmit queue holds fewer than 4 words.
- R2: While `rst` is high and after it, until the first access, `host_rdata` is 0x00, the write holding byte is 0x00, both queues are empty and both sticky bits are 0.
- R3: An access is a cycle with `host_sel`=1. `host_wr`=0 means a read and `host_wr`=1 means a write. A read with `host_addr`=0 returns bits 15..8 of the oldest receive word. A read with `host_addr`=1 returns bits 7..0 of that word. The byte appears on `host_rdata` after the clock edge that samples the read, and it holds until the next read.
- R4: A read at offset 1 while the receive queue is not empty removes one word. A read at offset 0 never removes a word.
- R5: A read of either offset while the receive queue is empty returns 0x00 and changes no queue state.
- R6: A write at offset 0 only loads the holding byte. A write at offset 1 adds the word {holding byte, written byte} to the transmit queue. `tx_data` shows the oldest transmit word, and words leave in the order they were added.
- R7: A write at offset 1 while the transmit queue is full and not being popped is discarded. It sets `tx_overflow`, which stays 1 until reset.
- R8: An `rx_push` while the receive queue is full and not being read at offset 1 is dropped. It sets `rx_overrun`, which stays 1 until reset.
- R9: `tx_valid` is 1 exactly when the transmit queue is not empty. A `tx_pop` while it is 0 has no effect.
- R10: A receive pop and an `rx_push` in the same cycle both take effect, even when the queue is full, and leave the level unchanged. The same holds for a transmit write at offset 1 together with a `tx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host access strobe for one cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | Byte offset: 0 upper half, 1 lower half |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| rx_push | input | 1 | Serial side adds a received word |
| rx_data | input | 16 | Received word |
| rx_not_empty | output | 1 | Receive queue holds data |
| rx_overrun | output | 1 | Sticky: a received word was dropped |
| tx_pop | input | 1 | Serial side takes the oldest transmit word |
| tx_data | output | 16 | Oldest transmit word |
| tx_valid | output | 1 | Transmit queue holds data |
| tx_not_full | output | 1 | Transmit queue has room |
| tx_overflow | output | 1 | Sticky: a host word was discarded |

## Verification
Every result is due after the single clock edge that samples the stimulus. This covers the read byte, both queue levels as seen through the flags, the transmit head and both sticky bits. No result appears later. The bench drives each access on the falling edge and compares every output 1 ns after the next rising edge against a queue model updated for that same edge. That edge is the first point where any registered result may change, and the last point before the next stimulus could disturb it.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;

  typedef enum logic {
    OFS_UPPER = 1'b0,
    OFS_LOWER = 1'b1
  } byte_ofs_e;

  typedef struct packed {
    logic rd_upper;
    logic rd_lower;
    logic wr_upper;
    logic wr_lower;
  } host_op_t;

endpackage

// File: rtl/host_decode.sv
module host_decode
  import fifo_port_pkg::*;
(
  input  logic     sel,
  input  logic     wr,
  input  logic     addr,
  output host_op_t op
);
  byte_ofs_e ofs;

  always_comb begin
    ofs         = byte_ofs_e'(addr);
    op.rd_upper = sel && !wr && (ofs == OFS_UPPER);
    op.rd_lower = sel && !wr && (ofs == OFS_LOWER);
    op.wr_upper = sel &&  wr && (ofs == OFS_UPPER);
    op.wr_lower = sel &&  wr && (ofs == OFS_LOWER);
  end
endmodule

// File: rtl/fifo_core.sv
module fifo_core #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             push_ok,
  output logic             pop_ok
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = pop && (count != '0);
  assign push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_no_pop_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !pop_ok);
  p_full_refuses_r7: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && count == CW'(DEPTH)) |-> !push_ok);
  p_balanced_level_r10: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/byte_fifo_port.sv
module byte_fifo_port
  import fifo_port_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              rx_push,
  input  logic [WORD_W-1:0] rx_data,
  output logic              rx_not_empty,
  output logic              rx_overrun,
  input  logic              tx_pop,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              tx_not_full,
  output logic              tx_overflow
);
  host_op_t          op;
  logic [WORD_W-1:0] rx_head;
  logic [CW-1:0]     rx_count, tx_count;
  logic              rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
  logic [BYTE_W-1:0] hold_q;

  host_decode u_decode (
    .sel(host_sel), .wr(host_wr), .addr(host_addr), .op(op)
  );

  fifo_core #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst(rst),
    .push(rx_push), .din(rx_data), .pop(op.rd_lower),
    .head(rx_head), .count(rx_count),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  fifo_core #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst(rst),
    .push(op.wr_lower), .din({hold_q, host_wdata}), .pop(tx_pop),
    .head(tx_data), .count(tx_count),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  assign rx_not_empty = (rx_count != '0);
  assign tx_valid     = (tx_count != '0);
  assign tx_not_full  = (tx_count != CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      hold_q      <= '0;
      rx_overrun  <= 1'b0;
      tx_overflow <= 1'b0;
    end else begin
      if (op.rd_upper || op.rd_lower) begin
        if (!rx_not_empty)    host_rdata <= '0;
        else if (op.rd_lower) host_rdata <= rx_head[BYTE_W-1:0];
        else                  host_rdata <= rx_head[WORD_W-1:BYTE_W];
      end
      if (op.wr_upper) hold_q <= host_wdata;
      if (rx_push && !rx_push_ok)    rx_overrun  <= 1'b1;
      if (op.wr_lower && !tx_push_ok) tx_overflow <= 1'b1;
    end
  end

  p_upper_read_keeps_level_r4: assert property (@(posedge clk) disable iff (rst)
    (op.rd_upper && !rx_push) |=> $stable(rx_count));
  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ((op.rd_upper || op.rd_lower) && !rx_not_empty) |=> (host_rdata == '0));
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun);
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    tx_overflow |=> tx_overflow);
  p_tx_pop_needs_data_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !tx_valid && !op.wr_lower) |=> (tx_count == '0));
  p_upper_write_no_push_r6: assert property (@(posedge clk) disable iff (rst)
    (op.wr_upper && !tx_pop) |=> $stable(tx_count));
endmodule

// File: tb/test_byte_fifo_port.sv
module test_byte_fifo_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        host_sel = 0, host_wr = 0, host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        rx_push = 0;
  logic [15:0] rx_data = 0;
  logic        rx_not_empty, rx_overrun;
  logic        tx_pop = 0;
  logic [15:0] tx_data;
  logic        tx_valid, tx_not_full, tx_overflow;

  byte_fifo_port i_byte_fifo_port (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_push(rx_push), .rx_data(rx_data),
    .rx_not_empty(rx_not_empty), .rx_overrun(rx_overrun),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_not_full(tx_not_full), .tx_overflow(tx_overflow)
  );

  int total = 0, bad = 0;
  logic [15:0] rq [4];
  logic [15:0] tq [4];
  int rc = 0, tc = 0;
  logic [7:0] hold_m = 0, rd_m = 0;
  logic ovr_m = 0, ofl_m = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step(string tag, bit sel, bit wr, bit addr, logic [7:0] wd,
                      bit rp, logic [15:0] rdat, bit tp);
    bit rd, pop, rok, tpop, hpush, tok;
    logic [15:0] word;
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_addr = addr; host_wdata = wd;
    rx_push = rp; rx_data = rdat; tx_pop = tp;
    @(posedge clk);
    #1;
    rd  = sel && !wr;
    pop = rd && addr && (rc > 0);
    rok = rp && ((rc < 4) || pop);
    if (rd) rd_m = (rc == 0) ? 8'h00 : (addr ? rq[0][7:0] : rq[0][15:8]);
    if (pop) begin
      for (int i = 0; i < 3; i++) rq[i] = rq[i+1];
      rc--;
    end
    if (rok) begin rq[rc] = rdat; rc++; end
    else if (rp) ovr_m = 1'b1;
    tpop  = tp && (tc > 0);
    hpush = sel && wr && addr;
    tok   = hpush && ((tc < 4) || tpop);
    word  = {hold_m, wd};
    if (sel && wr && !addr) hold_m = wd;
    if (tpop) begin
      for (int i = 0; i < 3; i++) tq[i] = tq[i+1];
      tc--;
    end
    if (tok) begin tq[tc] = word; tc++; end
    else if (hpush) ofl_m = 1'b1;
    chk({tag, " R3 host_rdata"}, 32'(host_rdata), 32'(rd_m));
    chk({tag, " R1 rx_not_empty"}, 32'(rx_not_empty), 32'(rc > 0));
    chk({tag, " R1 tx_not_full"}, 32'(tx_not_full), 32'(tc < 4));
    chk({tag, " R9 tx_valid"}, 32'(tx_valid), 32'(tc > 0));
    if (tc > 0) chk({tag, " R6 tx_data"}, 32'(tx_data), 32'(tq[0]));
    chk({tag, " R8 rx_overrun"}, 32'(rx_overrun), 32'(ovr_m));
    chk({tag, " R7 tx_overflow"}, 32'(tx_overflow), 32'(ofl_m));
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset host_rdata", 32'(host_rdata), 0);
    chk("R2 reset rx_not_empty", 32'(rx_not_empty), 0);
    chk("R2 reset tx_not_full", 32'(tx_not_full), 1);
    chk("R2 reset tx_valid", 32'(tx_valid), 0);
    chk("R2 reset rx_overrun", 32'(rx_overrun), 0);
    chk("R2 reset tx_overflow", 32'(tx_overflow), 0);
    @(negedge clk); rst = 1'b0;
    // R2: holding byte is zero, visible through the first committed word
    step("R2 hold", 1, 1, 1, 8'h5A, 0, 0, 0);
    step("R6 drain", 0, 0, 0, 0, 0, 0, 1);
    // R1 / R8: fill receive queue, fifth word dropped
    for (int i = 0; i < 5; i++) step("R8 fill", 0, 0, 0, 0, 1, 16'hA100 + 16'(i), 0);
    // R3 / R4: upper read twice does not pop, lower read pops
    step("R4 upper", 1, 0, 0, 0, 0, 0, 0);
    step("R4 upper again", 1, 0, 0, 0, 0, 0, 0);
    step("R3 lower", 1, 0, 1, 0, 0, 0, 0);
    step("R10 refill", 0, 0, 0, 0, 1, 16'hB0B0, 0);
    step("R10 rx pop+push full", 1, 0, 1, 0, 1, 16'hC3C3, 0);
    for (int i = 0; i < 4; i++) step("R4 drain", 1, 0, 1, 0, 0, 0, 0);
    step("R5 empty lower", 1, 0, 1, 0, 0, 0, 0);
    step("R5 empty upper", 1, 0, 0, 0, 0, 0, 0);
    // R6 / R7: transmit words built from two bytes
    for (int i = 0; i < 5; i++) begin
      step("R6 hi", 1, 1, 0, 8'h10 + 8'(i), 0, 0, 0);
      step("R7 lo", 1, 1, 1, 8'h80 + 8'(i), 0, 0, 0);
    end
    step("R10 tx push+pop full", 1, 1, 1, 8'hEE, 0, 0, 1);
    for (int i = 0; i < 4; i++) step("R6 pop", 0, 0, 0, 0, 0, 0, 1);
    step("R9 pop empty", 0, 0, 0, 0, 0, 0, 1);
    // constrained random traffic
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      bit s, w, a, p, t;
      s = ($urandom % 4) != 0;
      w = $urandom % 2;
      a = ($urandom % 3) != 0;
      p = ($urandom % 3) == 0;
      t = ($urandom % 3) == 0;
      step("R10 rand", s, w, a, 8'($urandom), p, 16'($urandom), t);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule